// File: doc/BRIEF.md
# Two-Bank SDRAM Command Controller

This block sits between a host request port and a single-data-rate SDRAM with two banks. Each bank holds 2048 rows of 256 columns of 16-bit words. The host hands over one read or write at a time over a valid/ready port. Each request carries a bank bit, an 11-bit row, an 8-bit column, write data and a two-bit byte mask. The controller turns each request into the right order of PRECHARGE, ACTIVE and column commands on the memory pins. It keeps one open row per bank, and both banks may have a row open at the same moment. A request that hits an open row goes straight to its column command.

After reset the controller first powers the memory up. It waits a set number of cycles with clock-enable low, raises clock-enable, precharges every bank, runs two refresh cycles and programs the mode register. Only then does it accept requests. The mode register sets burst reads with the chosen burst length, sequential order and the chosen CAS latency, and sets single-beat writes. A refresh timer asks for an AUTO REFRESH once every `REF_INTERVAL` cycles. Choose `REF_INTERVAL` so that the full 2048-row budget fits inside 32 ms (15.6 µs per refresh, scaled by the clock rate). A pending refresh closes all open rows and is served before any new host request.

Back-pressure on the request port works as follows. A request moves on the rising edge where both `req_valid` and `req_ready` are high. The host holds every request field steady until that edge. `req_ready` is high only when the controller is idle, no command timing is still running, and no refresh is waiting. Read data comes back on `rd_valid`/`rd_data` as a burst of `BURST_LEN` words, one per cycle, and cannot be stalled. The host must take each beat in the cycle it is shown.

Top module: `sdram_ctrl`

## Requirements
- R1: While reset is held and right after it, `sd_cke` is 0, the command pins show NOP and `req_ready` is 0. Commands on {cs_n, ras_n, cas_n, we_n} are coded as follows: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R2: After `INIT_WAIT` cycles, `sd_cke` rises. At least one further clock edge passes with CKE high before the first command. The first commands are then, in this order: PRECHARGE with A10=1, AUTO REFRESH, AUTO REFRESH, LOAD MODE. `req_ready` stays 0 until LOAD MODE has been issued. Only NOP is shown while CKE is low.
- R3: LOAD MODE drives BA=0 and an address word built as follows: A9=1 (single-beat writes), A[6:4]=`CAS_LAT`, A3=0 (sequential bursts), A[2:0]=log2(`BURST_LEN`). All other bits are 0.
- R4: A request is taken on the edge where `req_valid` and `req_ready` are both high. Exactly one memory access results from it.
- R5: A request to a bank with no open row issues ACTIVE with that bank on BA and the row on A[10:0]. The column command follows at least `T_RCD` cycles later.
- R6: A request to the row already open in its bank issues its column command with no PRECHARGE or ACTIVE before it.
- R7: A request to a bank whose open row differs issues PRECHARGE for that bank alone (A10=0, BA = bank). ACTIVE for the new row follows at least `T_RP` cycles later.
- R8: READ and WRITE carry the column on A[7:0], with A10=0 so the row stays open.
- R9: WRITE moves exactly one word. `sd_dq_out` holds the request data and `sd_dq_oe` is 1 in the WRITE cycle only. `sd_dqm` bit 0 covers the low byte and bit 1 the high byte; a 1 blocks that byte from being written.
- R10: A READ returns `BURST_LEN` words on consecutive cycles. The first word is valid `CAS_LAT` edges after the edge at which the memory samples READ. The words come in sequential order and wrap inside the `BURST_LEN`-aligned column block. DQM is 00 during reads.
- R11: AUTO REFRESH is issued at least once every `REF_INTERVAL` cycles (plus a short service delay). If any row is open, a PRECHARGE with A10=1 comes first. No bank is open when REFRESH is issued. After a refresh, every bank needs a fresh ACTIVE.
- R12: Two ACTIVE commands to the same bank are at least `T_RC` cycles apart.
- R13: An access to one bank leaves the open row of the other bank open, so a later hit there needs no PRECHARGE or ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled and driven on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | Bank select |
| req_row | input | 11 | Row address |
| req_col | input | 8 | Column address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte blocks for writes (1 = keep old byte) |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | 16 | Read beat data |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank address |
| sd_addr | output | 11 | Multiplexed row/column address; A10 = precharge-all / auto-precharge |
| sd_dqm | output | 2 | Byte masks |
| sd_dq_out | output | 16 | Data driven to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Data from memory |

## Verification
The bench watches for a row conflict, where a controller that skips the single-bank PRECHARGE would ACTIVE an already open bank and read the wrong row. It checks that switching to the other bank and back stays a row hit; a design that closes both banks would show an extra PRECHARGE or ACTIVE there. A read starting in the middle of a burst block is checked for wrap order and for the exact CAS-latency beat, which catches an off-by-one capture in the read pipeline. A masked write followed by a read-back exposes a swapped or inverted byte mask. Long idle gaps confirm that refresh closes every open row first and arrives within its interval.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_t;

  typedef enum logic [2:0] {
    ST_PWR, ST_IPRE, ST_IREF, ST_ILMR, ST_IDLE, ST_ROW, ST_REF
  } state_t;
endpackage

// File: rtl/sdc_refresh_timer.sv
`timescale 1ns/1ps
module sdc_refresh_timer #(
  parameter int INTERVAL = 3120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic pending
);
  localparam int CW = $clog2(INTERVAL + 1);
  logic [CW-1:0] cnt;
  logic expire;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= CW'(INTERVAL - 1);
      pending <= 1'b0;
    end else begin
      if (!run || expire) cnt <= CW'(INTERVAL - 1);
      else                cnt <= cnt - 1'b1;
      pending <= (pending && !ack) || expire;
    end
  end

  // a second expiry before the first is served would lose a refresh
  AST_NO_REF_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> !pending || ack); // R11
endmodule

// File: rtl/sdc_bank_track.sv
`timescale 1ns/1ps
module sdc_bank_track #(
  parameter int BANKS = 2,
  parameter int ROW_W = 11,
  parameter int T_RC  = 6,
  localparam int BA_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        act_en,
  input  logic                        pre_en,
  input  logic                        pre_all,
  input  logic [BA_W-1:0]             bank,
  input  logic [ROW_W-1:0]            act_row,
  output logic [BANKS-1:0]            open_o,
  output logic [BANKS-1:0][ROW_W-1:0] row_o,
  output logic [BANKS-1:0]            rc_ok
);
  localparam int RCW = $clog2(T_RC + 1);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic           sel;
    logic [RCW-1:0] rc_cnt;
    assign sel      = (bank == BA_W'(b));
    assign rc_ok[b] = (rc_cnt == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_o[b] <= 1'b0;
        row_o[b]  <= '0;
        rc_cnt    <= '0;
      end else begin
        if (act_en && sel) begin
          open_o[b] <= 1'b1;
          row_o[b]  <= act_row;
          rc_cnt    <= RCW'(T_RC - 1);
        end else begin
          if (pre_en && (pre_all || sel)) open_o[b] <= 1'b0;
          if (rc_cnt != '0) rc_cnt <= rc_cnt - 1'b1;
        end
      end
    end

    AST_ACT_ONLY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (act_en && sel) |-> !open_o[b]); // R7
    AST_RC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (act_en && sel) |-> rc_ok[b]); // R12
  end
endmodule

// File: rtl/sdc_read_pipe.sv
`timescale 1ns/1ps
module sdc_read_pipe #(
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int BW = $clog2(BURST_LEN + 1);
  logic [CAS_LAT-1:0] sr;
  logic [BW-1:0]      left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr       <= '0;
      left     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      sr <= {sr[CAS_LAT-2:0], issue};
      if (sr[CAS_LAT-1]) begin
        rd_valid <= 1'b1;
        rd_data  <= dq_in;
        left     <= BW'(BURST_LEN - 1);
      end else if (left != '0) begin
        rd_valid <= 1'b1;
        rd_data  <= dq_in;
        left     <= left - 1'b1;
      end else begin
        rd_valid <= 1'b0;
      end
    end
  end

  AST_RD_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (sr == '0) && (left == '0)); // R10
endmodule

// File: rtl/sdram_ctrl.sv
`timescale 1ns/1ps
module sdram_ctrl
  import sdc_pkg::*;
#(
  parameter int ROW_W        = 11,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 16,
  parameter int BANKS        = 2,
  parameter int AP_BIT       = 10,
  parameter int CAS_LAT      = 2,
  parameter int BURST_LEN    = 4,
  parameter int INIT_WAIT    = 40000,
  parameter int REF_INTERVAL = 3120,
  parameter int T_RP         = 3,
  parameter int T_RCD        = 3,
  parameter int T_RC         = 12,
  parameter int T_WR         = 2,
  parameter int T_MRD        = 2,
  localparam int BA_W = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int NB   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NB-1:0]     req_mask,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [NB-1:0]     sd_dqm,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);
  localparam int DLY_MAX = INIT_WAIT + CAS_LAT + BURST_LEN + T_RC + T_RP + T_RCD + T_WR + T_MRD;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);
  localparam logic [ROW_W-1:0] MODE_WORD =
    ROW_W'({1'b1, 2'b00, 3'(CAS_LAT), 1'b0, 3'($clog2(BURST_LEN))});

  state_t             state, nx_st;
  logic [DLY_W-1:0]   dly, nx_dly;
  logic               iref, nx_iref;
  cmd_t               cmd_q, nx_cmd;
  logic [BA_W-1:0]    ba_q, nx_ba;
  logic [ROW_W-1:0]   addr_q, nx_addr;
  logic [NB-1:0]      dqm_q, nx_dqm;
  logic               oe_q, nx_oe, cke_q, nx_cke;
  logic [DATA_W-1:0]  dqo_q;
  logic               accept, ref_ack, ref_pend, run;
  logic               r_write;
  logic [BA_W-1:0]    r_bank;
  logic [ROW_W-1:0]   r_row;
  logic [COL_W-1:0]   r_col;
  logic [DATA_W-1:0]  r_wdata;
  logic [NB-1:0]      r_mask;
  logic [BANKS-1:0]   bk_open, bk_rc_ok;
  logic [BANKS-1:0][ROW_W-1:0] bk_row;

  assign run       = (state == ST_IDLE) || (state == ST_ROW) || (state == ST_REF);
  assign req_ready = (state == ST_IDLE) && (dly == '0) && !ref_pend;
  assign accept    = req_valid && req_ready;

  always_comb begin
    nx_st = state; nx_dly = dly; nx_iref = iref; nx_cke = cke_q;
    nx_cmd = CMD_NOP; nx_ba = '0; nx_addr = '0; nx_dqm = '0; nx_oe = 1'b0;
    ref_ack = 1'b0;
    if (dly != '0) begin
      nx_dly = dly - 1'b1;
    end else begin
      unique case (state)
        ST_PWR: begin
          nx_cke = 1'b1; nx_dly = DLY_W'(1); nx_st = ST_IPRE;
        end
        ST_IPRE: begin
          nx_cmd = CMD_PRE; nx_addr[AP_BIT] = 1'b1;
          nx_dly = DLY_W'(T_RP - 1); nx_st = ST_IREF;
        end
        ST_IREF: begin
          nx_cmd = CMD_REF; nx_dly = DLY_W'(T_RC - 1); nx_iref = 1'b1;
          if (iref) nx_st = ST_ILMR;
        end
        ST_ILMR: begin
          nx_cmd = CMD_LMR; nx_addr = MODE_WORD;
          nx_dly = DLY_W'(T_MRD - 1); nx_st = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            nx_st = ST_REF;
            if (|bk_open) begin
              nx_cmd = CMD_PRE; nx_addr[AP_BIT] = 1'b1; nx_dly = DLY_W'(T_RP - 1);
            end
          end else if (accept) begin
            nx_st = ST_ROW;
          end
        end
        ST_ROW: begin
          nx_ba = r_bank;
          if (bk_open[r_bank] && bk_row[r_bank] == r_row) begin
            nx_addr = ROW_W'(r_col);
            nx_st   = ST_IDLE;
            if (r_write) begin
              nx_cmd = CMD_WR; nx_oe = 1'b1; nx_dqm = r_mask; nx_dly = DLY_W'(T_WR);
            end else begin
              nx_cmd = CMD_RD; nx_dly = DLY_W'(CAS_LAT + BURST_LEN - 1);
            end
          end else if (bk_open[r_bank]) begin
            nx_cmd = CMD_PRE; nx_dly = DLY_W'(T_RP - 1);
          end else if (bk_rc_ok[r_bank]) begin
            nx_cmd = CMD_ACT; nx_addr = r_row; nx_dly = DLY_W'(T_RCD - 1);
          end
        end
        ST_REF: begin
          if (&bk_rc_ok) begin
            nx_cmd = CMD_REF; ref_ack = 1'b1;
            nx_dly = DLY_W'(T_RC - 1); nx_st = ST_IDLE;
          end
        end
        default: nx_st = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_PWR; dly <= DLY_W'(INIT_WAIT); iref <= 1'b0;
      cmd_q <= CMD_NOP; ba_q <= '0; addr_q <= '0; dqm_q <= '0;
      oe_q <= 1'b0; cke_q <= 1'b0; dqo_q <= '0;
      r_write <= 1'b0; r_bank <= '0; r_row <= '0; r_col <= '0;
      r_wdata <= '0; r_mask <= '0;
    end else begin
      state <= nx_st; dly <= nx_dly; iref <= nx_iref;
      cmd_q <= nx_cmd; ba_q <= nx_ba; addr_q <= nx_addr; dqm_q <= nx_dqm;
      oe_q <= nx_oe; cke_q <= nx_cke; dqo_q <= r_wdata;
      if (accept) begin
        r_write <= req_write; r_bank <= req_bank; r_row <= req_row;
        r_col <= req_col; r_wdata <= req_wdata; r_mask <= req_mask;
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_cke    = cke_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign sd_dqm    = dqm_q;
  assign sd_dq_oe  = oe_q;
  assign sd_dq_out = dqo_q;

  sdc_bank_track #(.BANKS(BANKS), .ROW_W(ROW_W), .T_RC(T_RC)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .act_en(nx_cmd == CMD_ACT), .pre_en(nx_cmd == CMD_PRE),
    .pre_all(nx_addr[AP_BIT]), .bank(nx_ba), .act_row(nx_addr),
    .open_o(bk_open), .row_o(bk_row), .rc_ok(bk_rc_ok));

  sdc_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst_n(rst_n), .run(run), .ack(ref_ack), .pending(ref_pend));

  sdc_read_pipe #(.CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .issue(cmd_q == CMD_RD),
    .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data));

  AST_CKE_LOW_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cke |-> cmd_q == CMD_NOP); // R2
  AST_COL_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> !sd_addr[AP_BIT]); // R8
  AST_DQ_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> cmd_q == CMD_WR); // R9
  AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (nx_cmd == CMD_REF) |-> bk_open == '0); // R11
  AST_NO_READY_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> sd_cke && !ref_pend); // R2
endmodule

// File: tb/sdram_ctrl_test.sv
`timescale 1ns/1ps
module sdram_ctrl_test;
  localparam int CL = 2, BL = 4, INITW = 20, REFI = 1500;
  localparam int TRP = 2, TRCD = 2, TRC = 6, TWR = 2, TMRD = 2;
  localparam logic [3:0] C_LMR = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
    C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_bank = 1'b0;
  logic [10:0] req_row = '0;
  logic [7:0]  req_col = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_dq_oe;
  logic [15:0] rd_data, sd_dq_out;
  logic [15:0] sd_dq_in = '0;
  logic [10:0] sd_addr;
  logic [1:0]  sd_dqm;

  always #2.5 clk = ~clk;

  sdram_ctrl #(.CAS_LAT(CL), .BURST_LEN(BL), .INIT_WAIT(INITW), .REF_INTERVAL(REFI),
    .T_RP(TRP), .T_RCD(TRCD), .T_RC(TRC), .T_WR(TWR), .T_MRD(TMRD)) uut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  // command log (non-NOP commands sampled with CKE high)
  int lg_cyc [1024];
  logic [3:0] lg_cmd [1024];
  logic [10:0] lg_addr [1024];
  logic lg_ba [1024];
  logic [1:0] lg_dqm [1024];
  logic [15:0] lg_dq [1024];
  logic lg_oe [1024];
  int n_log = 0;

  // behavioural memory
  logic [15:0] mem [int];
  logic [15:0] expm [int];
  int orow [2];
  int rd_on = 0, rd_at = 0, rd_beat = 0, rd_key = 0;

  function automatic logic [15:0] dflt(int k);
    return 16'((k * 977) ^ 16'h5A5A);
  endfunction
  function automatic int mkey(int b, int r, int c);
    return (b << 19) | (r << 8) | c;
  endfunction
  function automatic int bcol(int c, int i);
    return (c & ~(BL - 1)) | ((c + i) & (BL - 1));
  endfunction

  always @(posedge clk) begin
    logic [3:0] c;
    logic [15:0] v;
    int k;
    cyc = cyc + 1;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rd_on != 0 && cyc >= rd_at) begin
      k = (rd_key & ~255) | bcol(rd_key & 255, rd_beat);
      sd_dq_in <= mem.exists(k) ? mem[k] : dflt(k);
      rd_beat = rd_beat + 1;
      if (rd_beat == BL) rd_on = 0;
    end
    if (sd_cke && c != C_NOP && n_log < 1024) begin
      lg_cyc[n_log] = cyc; lg_cmd[n_log] = c; lg_addr[n_log] = sd_addr;
      lg_ba[n_log] = sd_ba; lg_dqm[n_log] = sd_dqm; lg_dq[n_log] = sd_dq_out;
      lg_oe[n_log] = sd_dq_oe; n_log = n_log + 1;
      if (c == C_ACT) orow[sd_ba] = int'(sd_addr);
      if (c == C_WR) begin
        k = mkey(sd_ba, orow[sd_ba], int'(sd_addr[7:0]));
        v = mem.exists(k) ? mem[k] : dflt(k);
        if (!sd_dqm[0]) v[7:0] = sd_dq_out[7:0];
        if (!sd_dqm[1]) v[15:8] = sd_dq_out[15:8];
        mem[k] = v;
      end
      if (c == C_RD) begin
        rd_on = 1; rd_at = cyc + CL - 1; rd_beat = 0;
        rd_key = mkey(sd_ba, orow[sd_ba], int'(sd_addr[7:0]));
      end
    end
  end

  // read capture and init observation, sampled away from the edge
  logic [15:0] cap_d [16];
  int cap_c [16];
  int cap_n = 0, cke_cyc = -1, early_ready = 0;
  always @(negedge clk) begin
    if (rd_valid && cap_n < 16) begin cap_d[cap_n] = rd_data; cap_c[cap_n] = cyc; cap_n++; end
    if (sd_cke && cke_cyc < 0) cke_cyc = cyc;
    if (req_ready && n_log < 4) early_ready = 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int find(input logic [3:0] c, input int from);
    for (int i = from; i < n_log; i++) if (lg_cmd[i] == c) return i;
    return -1;
  endfunction

  function automatic int count(input logic [3:0] c, input int from, input int upto);
    int n = 0;
    for (int i = from; i < upto && i < n_log; i++) if (lg_cmd[i] == c) n++;
    return n;
  endfunction

  task automatic send(input bit w, input bit b, input int row, input int col,
                      input logic [15:0] d, input logic [1:0] m);
    int t = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_bank = b; req_row = 11'(row);
    req_col = 8'(col); req_wdata = d; req_mask = m;
    while (!req_ready && t < 4000) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input bit b, input int row, input int col,
                          input logic [15:0] d, input logic [1:0] m, output int wi);
    int k = mkey(b, row, col);
    logic [15:0] v = expm.exists(k) ? expm[k] : dflt(k);
    int mark = n_log;
    if (!m[0]) v[7:0] = d[7:0];
    if (!m[1]) v[15:8] = d[15:8];
    expm[k] = v;
    send(1'b1, b, row, col, d, m);
    settle(12);
    wi = find(C_WR, mark);
    chk(wi >= 0 && count(C_WR, mark, n_log) == 1, "R4", "one write per request", count(C_WR, mark, n_log), 1);
    if (wi >= 0) begin
      chk(lg_addr[wi][7:0] == 8'(col) && !lg_addr[wi][10], "R8", "write column/A10", int'(lg_addr[wi]), col);
      chk(lg_dq[wi] == d && lg_oe[wi] && lg_dqm[wi] == m, "R9", "write data/mask", int'({lg_dqm[wi], lg_dq[wi]}), int'({m, d}));
    end
  endtask

  task automatic do_read(input bit b, input int row, input int col, output int ri);
    int mark = n_log;
    int t = 0;
    cap_n = 0;
    send(1'b0, b, row, col, '0, '0);
    while (cap_n < BL && t < 60) begin @(negedge clk); t++; end
    settle(6);
    ri = find(C_RD, mark);
    chk(cap_n == BL && ri >= 0, "R10", "beats returned", cap_n, BL);
    if (ri >= 0 && cap_n >= BL) begin
      chk(cap_c[0] - lg_cyc[ri] == CL, "R10", "first beat latency", cap_c[0] - lg_cyc[ri], CL);
      chk(lg_dqm[ri] == 2'b00 && !lg_addr[ri][10], "R10", "read dqm/A10", int'(lg_dqm[ri]), 0);
      for (int i = 0; i < BL; i++) begin
        int k = mkey(b, row, bcol(col, i));
        logic [15:0] e = expm.exists(k) ? expm[k] : dflt(k);
        chk(cap_d[i] == e && cap_c[i] == cap_c[0] + i, "R10", "burst beat", int'(cap_d[i]), int'(e));
      end
    end
  endtask

  int lmr_i = 3;

  task automatic t_reset;
    settle(3);
    chk(!sd_cke && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && !req_ready, "R1", "reset state",
        int'({sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, req_ready}), int'({1'b0, C_NOP, 1'b0}));
    rst_n = 1'b1;
  endtask

  task automatic t_init;
    int t = 0;
    while (!req_ready && t < 500) begin @(negedge clk); t++; end
    chk(n_log >= 4, "R2", "init command count", n_log, 4);
    if (n_log >= 4) begin
      chk(lg_cyc[0] - cke_cyc >= 2, "R2", "CKE lead", lg_cyc[0] - cke_cyc, 2);
      chk(lg_cmd[0] == C_PRE && lg_addr[0][10], "R2", "first precharge-all", int'(lg_cmd[0]), int'(C_PRE));
      chk(lg_cmd[1] == C_REF && lg_cmd[2] == C_REF, "R2", "two refreshes", int'({lg_cmd[1], lg_cmd[2]}), int'({C_REF, C_REF}));
      chk(lg_cmd[3] == C_LMR && lg_addr[3] == 11'h222 && !lg_ba[3], "R3", "mode word", int'(lg_addr[3]), 'h222);
    end
    chk(early_ready == 0, "R2", "ready before mode load", early_ready, 0);
  endtask

  task automatic t_miss_write;
    int mark = n_log, wi, ai;
    do_write(1'b0, 5, 8, 16'hC3A1, 2'b00, wi);
    ai = find(C_ACT, mark);
    chk(ai >= 0 && !lg_ba[ai] && lg_addr[ai] == 11'd5, "R5", "activate bank/row", ai >= 0 ? int'(lg_addr[ai]) : -1, 5);
    if (ai >= 0 && wi > ai) chk(lg_cyc[wi] - lg_cyc[ai] >= TRCD, "R5", "tRCD gap", lg_cyc[wi] - lg_cyc[ai], TRCD);
  endtask

  task automatic t_hit_read;
    int mark = n_log, ri;
    do_read(1'b0, 5, 8, ri);
    chk(count(C_ACT, mark, n_log) + count(C_PRE, mark, n_log) == 0, "R6", "hit needs no row commands",
        count(C_ACT, mark, n_log) + count(C_PRE, mark, n_log), 0);
  endtask

  task automatic t_masked;
    int wi, ri;
    do_write(1'b0, 5, 8, 16'h7E11, 2'b01, wi);
    do_read(1'b0, 5, 8, ri);
    do_write(1'b0, 5, 9, 16'h0BB0, 2'b10, wi);
    do_read(1'b0, 5, 8, ri);
  endtask

  task automatic t_two_banks;
    int wi, ri, mark;
    do_write(1'b1, 7, 3, 16'h1234, 2'b00, wi);
    mark = n_log;
    do_read(1'b0, 5, 8, ri);
    chk(count(C_ACT, mark, n_log) + count(C_PRE, mark, n_log) == 0, "R13", "bank0 row kept open",
        count(C_ACT, mark, n_log) + count(C_PRE, mark, n_log), 0);
    mark = n_log;
    do_read(1'b1, 7, 0, ri);
    chk(count(C_ACT, mark, n_log) == 0, "R13", "bank1 row kept open", count(C_ACT, mark, n_log), 0);
  endtask

  task automatic t_conflict;
    int mark = n_log, ri, pi, ai;
    do_read(1'b0, 9, 0, ri);
    pi = find(C_PRE, mark);
    ai = find(C_ACT, mark);
    chk(pi >= 0 && !lg_ba[pi] && !lg_addr[pi][10], "R7", "single-bank precharge", pi >= 0 ? int'(lg_addr[pi]) : -1, 0);
    chk(ai > pi && pi >= 0 && lg_addr[ai] == 11'd9, "R7", "reactivate new row", ai, pi + 1);
    if (ai > pi && pi >= 0) chk(lg_cyc[ai] - lg_cyc[pi] >= TRP, "R7", "tRP gap", lg_cyc[ai] - lg_cyc[pi], TRP);
  endtask

  task automatic t_wrap;
    int ri, wi;
    do_write(1'b0, 9, 8, 16'hBEEF, 2'b00, wi);
    do_read(1'b0, 9, 10, ri);
  endtask

  task automatic t_refresh;
    int mark = n_log, r0, r1, ri, ma;
    settle(2 * REFI + 40);
    r0 = find(C_REF, mark);
    chk(r0 > 0 && lg_cmd[r0 - 1] == C_PRE && lg_addr[r0 - 1][10], "R11", "precharge-all before refresh",
        r0 > 0 ? int'(lg_cmd[r0 - 1]) : -1, int'(C_PRE));
    r1 = r0 >= 0 ? find(C_REF, r0 + 1) : -1;
    chk(r1 > r0 && lg_cyc[r1] - lg_cyc[r0] <= REFI + 20, "R11", "refresh interval",
        r1 > r0 ? lg_cyc[r1] - lg_cyc[r0] : -1, REFI);
    ma = n_log;
    do_read(1'b0, 9, 8, ri);
    chk(count(C_ACT, ma, n_log) == 1, "R11", "row reopened after refresh", count(C_ACT, ma, n_log), 1);
  endtask

  task automatic t_rc_scan;
    int last [2] = '{-1000, -1000};
    int worst = 1000;
    for (int i = 0; i < n_log; i++)
      if (lg_cmd[i] == C_ACT) begin
        if (lg_cyc[i] - last[lg_ba[i]] < worst) worst = lg_cyc[i] - last[lg_ba[i]];
        last[lg_ba[i]] = lg_cyc[i];
      end
    chk(worst >= TRC, "R12", "ACT-to-ACT spacing", worst, TRC);
  endtask

  initial begin
    t_reset;
    t_init;
    t_miss_write;
    t_hit_read;
    t_masked;
    t_two_banks;
    t_conflict;
    t_wrap;
    t_refresh;
    t_rc_scan;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule